// File: doc/BRIEF.md
# Banked Register-File Read-Port Arbiter

This block is a single pipeline stage between instruction issue and a physical register file that is split into interleaved banks. Instructions are issued speculatively, and no bank check happens in the select loop. In the following cycle this stage receives every source-operand read request of the issue group. Each request carries a valid bit, a bypass flag and a physical register index. The stage maps each request onto the small set of read ports of its bank and drives, one cycle later, a registered description of every port: whether it is used and which row it reads.

For every request the stage also reports whether the request reads from a port, and if so which port of its bank supplies the value. Downstream operand multiplexers use this to steer data. Two requests for the same register share one port. A request whose value will arrive over the bypass network never claims a port. An instruction with any operand that could not be served is flagged on its slot's reissue line, so the issue window can squash it and replay it. The stage never stalls and holds no requests over from one cycle to the next.

With the default parameters the register file has 512 registers in 16 banks, each bank has 4 read ports, and the issue group has 8 slots with 2 source operands each. Request number r belongs to slot r/2 and is operand r%2 of that slot.

Top module: `bank_rd_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is zero, whatever the request inputs carry.
- R2: A request's register index splits into a bank number (bits 3:0) and a row within the bank (bits 8:4). Port p of bank b is output bit b*4+p of `port_vld`, and its row is field b*4+p of `port_row`, 5 bits each. Unused ports show row 0.
- R3: Within a bank, the distinct registers that need a port are numbered in request order, from request 0 (slot 0 operand 0) up to request 15. The k-th such register, counting from 0, is given port k, so the used ports of a bank are always 0..n-1.
- R4: A bank serves at most 4 distinct registers per cycle. The fifth and later distinct registers in request order get no port.
- R5: All requests that name the same register in one cycle use a single port. Each of them reports the same port-select value and has its `req_on_port` bit set.
- R6: A valid request with its bypass flag set gets no port, never sets `req_on_port`, and never causes a reissue.
- R7: A request with its valid bit clear has no effect on any output. A cycle with no valid request produces no port grants and no reissue flags.
- R8: `slot_reissue[s]` is 1 exactly when operand 0 or operand 1 of slot s needed a port and did not get one. When that happens, the slot's other operand keeps its grant if it won.
- R9: Outputs are registered. They reflect the requests present at the previous rising clock edge and hold until the next edge. A new request group is accepted every cycle.
- R10: `req_psel` (2 bits per request) holds the port number within the request's bank when `req_on_port` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 16 | Request valid, one bit per request |
| req_bypass | input | 16 | Request is supplied by the bypass network |
| req_idx | input | 144 | Physical register index, 9 bits per request |
| port_vld | output | 64 | Read port in use, one bit per bank port |
| port_row | output | 320 | Row address, 5 bits per bank port |
| req_psel | output | 32 | Port within the bank that feeds each request |
| req_on_port | output | 16 | Request is served from a register-file port |
| slot_reissue | output | 8 | Instruction in this slot must be squashed and reissued |

## Verification
The stage keeps no state from one cycle to the next, so an internal fault shows up at the ports one cycle after the request group that triggered it, and the next group clears it. A wrong leader match shows as a doubled port or as split port-select values for one register. A wrong rank count shows as a gap in a bank's used ports or as a wrong reissue slot. A wrong bank or row slice shows as a request pointing at an unused port or at the wrong row. Random groups drawn from a small register pool force dense sharing and over-subscription, and directed groups pin down the capacity limit, bypass and idle cycles.

// File: rtl/bank_rd_arb_pkg.sv
package bank_rd_arb_pkg;
    // default geometry of the register file and the issue group
    localparam int DEF_NUM_REGS  = 512;
    localparam int DEF_NUM_BANKS = 16;
    localparam int DEF_PORTS     = 4;
    localparam int DEF_ISSUE_W   = 8;
    localparam int DEF_SRCS      = 2;
endpackage

// File: rtl/bank_rd_decode.sv
module bank_rd_decode #(
    parameter int NREQ   = 16,
    parameter int IDX_W  = 9,
    parameter int BANK_W = 4,
    parameter int ROW_W  = 5
) (
    input  logic [NREQ-1:0]             req_valid,
    input  logic [NREQ-1:0]             req_bypass,
    input  logic [NREQ*IDX_W-1:0]       req_idx,
    output logic [NREQ-1:0]             need,
    output logic [NREQ-1:0][IDX_W-1:0]  idx,
    output logic [NREQ-1:0][BANK_W-1:0] bank,
    output logic [NREQ-1:0][ROW_W-1:0]  row
);
    // low index bits select the bank, the rest select the row
    for (genvar r = 0; r < NREQ; r++) begin : g_req
        assign need[r] = req_valid[r] & ~req_bypass[r];
        assign idx[r]  = req_idx[r*IDX_W +: IDX_W];
        assign bank[r] = idx[r][BANK_W-1:0];
        assign row[r]  = idx[r][IDX_W-1:BANK_W];
    end
endmodule

// File: rtl/bank_rd_share.sv
module bank_rd_share #(
    parameter int NREQ  = 16,
    parameter int IDX_W = 9,
    parameter int REQ_W = 4
) (
    input  logic [NREQ-1:0]            need,
    input  logic [NREQ-1:0][IDX_W-1:0] idx,
    output logic [NREQ-1:0]            leader,
    output logic [NREQ-1:0][REQ_W-1:0] lead_of
);
    // the earliest request naming a register leads; later ones follow it
    always_comb begin
        for (int r = 0; r < NREQ; r++) begin
            lead_of[r] = REQ_W'(r);
            leader[r]  = need[r];
            for (int j = r - 1; j >= 0; j--) begin
                if (need[r] && need[j] && (idx[j] == idx[r])) begin
                    lead_of[r] = REQ_W'(j);
                    leader[r]  = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/bank_rd_rank.sv
module bank_rd_rank #(
    parameter int NREQ   = 16,
    parameter int BANK_W = 4,
    parameter int CNT_W  = 5
) (
    input  logic [NREQ-1:0]             leader,
    input  logic [NREQ-1:0][BANK_W-1:0] bank,
    output logic [NREQ-1:0][CNT_W-1:0]  rank
);
    // number of earlier leaders that target the same bank
    always_comb begin
        for (int r = 0; r < NREQ; r++) begin
            rank[r] = '0;
            for (int j = 0; j < r; j++) begin
                if (leader[j] && (bank[j] == bank[r])) begin
                    rank[r] = rank[r] + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/bank_rd_arb.sv
module bank_rd_arb
    import bank_rd_arb_pkg::*;
#(
    parameter int NUM_REGS  = DEF_NUM_REGS,
    parameter int NUM_BANKS = DEF_NUM_BANKS,
    parameter int PORTS     = DEF_PORTS,
    parameter int ISSUE_W   = DEF_ISSUE_W,
    parameter int SRCS      = DEF_SRCS,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ROW_W    = IDX_W - BANK_W,
    localparam int PSEL_W   = $clog2(PORTS),
    localparam int NREQ     = ISSUE_W * SRCS,
    localparam int NPORT    = NUM_BANKS * PORTS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREQ-1:0]         req_valid,
    input  logic [NREQ-1:0]         req_bypass,
    input  logic [NREQ*IDX_W-1:0]   req_idx,
    output logic [NPORT-1:0]        port_vld,
    output logic [NPORT*ROW_W-1:0]  port_row,
    output logic [NREQ*PSEL_W-1:0]  req_psel,
    output logic [NREQ-1:0]         req_on_port,
    output logic [ISSUE_W-1:0]      slot_reissue
);
    localparam int REQ_W  = $clog2(NREQ);
    localparam int CNT_W  = REQ_W + 1;
    localparam int PIDX_W = BANK_W + PSEL_W;
    localparam logic [CNT_W-1:0] PORTS_C = CNT_W'(PORTS);

    logic [NREQ-1:0]             need;
    logic [NREQ-1:0][IDX_W-1:0]  idx;
    logic [NREQ-1:0][BANK_W-1:0] bank;
    logic [NREQ-1:0][ROW_W-1:0]  row;
    logic [NREQ-1:0]             leader;
    logic [NREQ-1:0][REQ_W-1:0]  lead_of;
    logic [NREQ-1:0][CNT_W-1:0]  rank;

    bank_rd_decode #(
        .NREQ(NREQ), .IDX_W(IDX_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) decode_i (
        .req_valid (req_valid),
        .req_bypass(req_bypass),
        .req_idx   (req_idx),
        .need      (need),
        .idx       (idx),
        .bank      (bank),
        .row       (row)
    );

    bank_rd_share #(
        .NREQ(NREQ), .IDX_W(IDX_W), .REQ_W(REQ_W)
    ) share_i (
        .need   (need),
        .idx    (idx),
        .leader (leader),
        .lead_of(lead_of)
    );

    bank_rd_rank #(
        .NREQ(NREQ), .BANK_W(BANK_W), .CNT_W(CNT_W)
    ) rank_i (
        .leader(leader),
        .bank  (bank),
        .rank  (rank)
    );

    // a leader wins when its rank fits within the bank's port count
    logic [NREQ-1:0] lead_won;
    for (genvar r = 0; r < NREQ; r++) begin : g_win
        assign lead_won[r] = leader[r] && (rank[r] < PORTS_C);
    end

    // per-request result: follow the leader's outcome
    logic [NREQ-1:0]              on_port_d;
    logic [NREQ-1:0]              lost_d;
    logic [NREQ-1:0][PSEL_W-1:0]  psel_d;

    always_comb begin
        for (int r = 0; r < NREQ; r++) begin
            on_port_d[r] = need[r] && lead_won[lead_of[r]];
            lost_d[r]    = need[r] && !lead_won[lead_of[r]];
            psel_d[r]    = on_port_d[r] ? rank[lead_of[r]][PSEL_W-1:0] : '0;
        end
    end

    // per-slot reissue: any losing operand squashes the instruction
    logic [ISSUE_W-1:0] reissue_d;
    for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
        assign reissue_d[s] = |lost_d[s*SRCS +: SRCS];
    end

    // port table: each winning leader occupies {bank, rank}
    logic [NPORT-1:0]            pv_d;
    logic [NPORT-1:0][ROW_W-1:0] prow_d;

    always_comb begin
        logic [PIDX_W-1:0] k;
        pv_d   = '0;
        prow_d = '0;
        for (int r = 0; r < NREQ; r++) begin
            k = {bank[r], rank[r][PSEL_W-1:0]};
            if (lead_won[r]) begin
                pv_d[k]   = 1'b1;
                prow_d[k] = row[r];
            end
        end
    end

    // output register stage
    logic [NPORT-1:0]            pv_q;
    logic [NPORT-1:0][ROW_W-1:0] prow_q;
    logic [NREQ-1:0][PSEL_W-1:0] psel_q;
    logic [NREQ-1:0]             on_port_q;
    logic [ISSUE_W-1:0]          reissue_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pv_q      <= '0;
            prow_q    <= '0;
            psel_q    <= '0;
            on_port_q <= '0;
            reissue_q <= '0;
        end else begin
            pv_q      <= pv_d;
            prow_q    <= prow_d;
            psel_q    <= psel_d;
            on_port_q <= on_port_d;
            reissue_q <= reissue_d;
        end
    end

    assign port_vld     = pv_q;
    assign port_row     = prow_q;
    assign req_psel     = psel_q;
    assign req_on_port  = on_port_q;
    assign slot_reissue = reissue_q;
endmodule

// File: rtl/bank_rd_arb_chk.sv
module bank_rd_arb_chk #(
    parameter int NUM_BANKS = 16,
    parameter int PORTS     = 4,
    parameter int ISSUE_W   = 8,
    parameter int SRCS      = 2,
    parameter int IDX_W     = 9,
    parameter int BANK_W    = 4,
    parameter int ROW_W     = 5,
    parameter int PSEL_W    = 2,
    parameter int NREQ      = 16,
    parameter int NPORT     = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NREQ-1:0]        req_valid,
    input logic [NREQ-1:0]        req_bypass,
    input logic [NREQ*IDX_W-1:0]  req_idx,
    input logic [NPORT-1:0]       port_vld,
    input logic [NPORT*ROW_W-1:0] port_row,
    input logic [NREQ*PSEL_W-1:0] req_psel,
    input logic [NREQ-1:0]        req_on_port,
    input logic [ISSUE_W-1:0]     slot_reissue
);
    localparam int PIDX_W = BANK_W + PSEL_W;

    // copy of the previous request indices, used to locate each port
    logic [NREQ*IDX_W-1:0] idx_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= req_idx;
    end

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid == '0) |=> (port_vld == '0 && slot_reissue == '0 && req_on_port == '0));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar p = 1; p < PORTS; p++) begin : g_port
            // R3
            port_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
                port_vld[b*PORTS+p] |-> port_vld[b*PORTS+p-1]);
        end
    end

    for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
        // R6
        bypass_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((req_valid[s*SRCS +: SRCS] & ~req_bypass[s*SRCS +: SRCS]) == '0) |=> !slot_reissue[s]);
        // R8
        reissue_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            slot_reissue[s] |-> ($past(req_valid[s*SRCS +: SRCS] & ~req_bypass[s*SRCS +: SRCS]) != '0));
    end

    for (genvar r = 0; r < NREQ; r++) begin : g_req
        logic [PIDX_W-1:0] k;
        logic [PSEL_W-1:0] ps;
        assign ps = req_psel[r*PSEL_W +: PSEL_W];
        assign k  = {idx_q[r*IDX_W +: BANK_W], ps};
        // R2
        route_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_on_port[r] |-> (port_vld[k] &&
                port_row[k*ROW_W +: ROW_W] == idx_q[r*IDX_W+BANK_W +: ROW_W]));
        // R10
        psel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req_on_port[r] |-> (ps == '0));
        for (genvar j = 0; j < r; j++) begin : g_pair
            // R5
            share_same_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (req_on_port[r] && req_on_port[j] &&
                 idx_q[r*IDX_W +: IDX_W] == idx_q[j*IDX_W +: IDX_W])
                |-> (ps == req_psel[j*PSEL_W +: PSEL_W]));
        end
    end
endmodule

bind bank_rd_arb bank_rd_arb_chk #(
    .NUM_BANKS(NUM_BANKS), .PORTS(PORTS), .ISSUE_W(ISSUE_W), .SRCS(SRCS),
    .IDX_W(IDX_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .PSEL_W(PSEL_W),
    .NREQ(NREQ), .NPORT(NPORT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bypass(req_bypass),
    .req_idx(req_idx), .port_vld(port_vld), .port_row(port_row),
    .req_psel(req_psel), .req_on_port(req_on_port), .slot_reissue(slot_reissue)
);

// File: tb/bank_rd_arb_tb_top.sv
`timescale 1ns/1ps
module bank_rd_arb_tb_top;
    localparam int NR = 16;   // requests
    localparam int NB = 16;   // banks
    localparam int NP = 4;    // ports per bank
    localparam int IW = 9;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0]       vld;
    logic [NR-1:0]       byp;
    logic [NR*IW-1:0]    idx;
    logic [NB*NP-1:0]    port_vld;
    logic [NB*NP*RW-1:0] port_row;
    logic [NR*2-1:0]     req_psel;
    logic [NR-1:0]       req_on_port;
    logic [7:0]          slot_reissue;

    always #10 clk = ~clk;

    bank_rd_arb dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(vld), .req_bypass(byp), .req_idx(idx),
        .port_vld(port_vld), .port_row(port_row), .req_psel(req_psel),
        .req_on_port(req_on_port), .slot_reissue(slot_reissue)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [NB*NP-1:0]    e_pv;
    logic [NB*NP*RW-1:0] e_row;
    logic [NR*2-1:0]     e_psel;
    logic [NR-1:0]       e_on;
    logic [7:0]          e_re;

    task automatic check(string tag, string what, logic [319:0] act, logic [319:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // reference: per bank, a list of distinct registers in request order
    task automatic calc();
        int cnt [NB];
        logic [IW-1:0] lst [NB][NR];
        e_pv = '0; e_row = '0; e_psel = '0; e_on = '0; e_re = '0;
        for (int b = 0; b < NB; b++) cnt[b] = 0;
        for (int r = 0; r < NR; r++) begin
            if (vld[r] && !byp[r]) begin
                logic [IW-1:0] i;
                int b;
                int pos;
                i = idx[r*IW +: IW];
                b = int'(i[3:0]);
                pos = -1;
                for (int k = 0; k < cnt[b]; k++) if (lst[b][k] == i) pos = k;
                if (pos < 0) begin
                    pos = cnt[b];
                    lst[b][pos] = i;
                    cnt[b]++;
                    if (pos < NP) begin
                        e_pv[b*NP+pos] = 1'b1;
                        e_row[(b*NP+pos)*RW +: RW] = i[8:4];
                    end
                end
                if (pos < NP) begin
                    e_on[r] = 1'b1;
                    e_psel[r*2 +: 2] = 2'(pos);
                end else begin
                    e_re[r/2] = 1'b1;
                end
            end
        end
    endtask

    task automatic compare_all();
        check("R3", "port_vld", port_vld, e_pv);
        check("R2", "port_row", port_row, e_row);
        check("R5", "req_psel", req_psel, e_psel);
        check("R10", "req_on_port", req_on_port, e_on);
        check("R8", "slot_reissue", slot_reissue, e_re);
    endtask

    // inputs are set at a falling edge before the call
    task automatic apply();
        logic [NB*NP-1:0] p_pv;
        logic [7:0] p_re;
        p_pv = e_pv;
        p_re = e_re;
        calc();
        #1;
        // R9: outputs still show the previous group until the next edge
        check("R9", "hold port_vld", port_vld, p_pv);
        check("R9", "hold reissue", slot_reissue, p_re);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic clear_req();
        vld = '0; byp = '0; idx = '0;
    endtask

    task automatic set_req(int r, logic [IW-1:0] i, bit b);
        vld[r] = 1'b1;
        byp[r] = b;
        idx[r*IW +: IW] = i;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        e_pv = '0; e_row = '0; e_psel = '0; e_on = '0; e_re = '0;
        vld = '1; byp = '0; idx = '1;
        repeat (3) @(negedge clk);
        // R1: outputs zero during reset despite busy inputs
        check("R1", "reset port_vld", port_vld, '0);
        check("R1", "reset reissue", slot_reissue, '0);
        check("R1", "reset on_port", req_on_port, '0);
        clear_req();
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "after reset row", port_row, '0);
        check("R1", "after reset psel", req_psel, '0);

        // R4 / R3: six distinct registers in bank 3
        clear_req();
        for (int r = 0; r < 6; r++) set_req(r, IW'((r << 4) | 3), 1'b0);
        apply();
        check("R4", "slot2 reissued", slot_reissue, 8'h04);
        check("R4", "bank3 full", port_vld[15:12], 4'hF);
        check("R3", "req3 on port3", req_psel[7:6], 2'd3);

        // R5: all requests share one register
        clear_req();
        for (int r = 0; r < NR; r++) set_req(r, 9'h1A5, 1'b0);
        apply();
        check("R5", "one port used", port_vld, 64'h1 << 20);
        check("R5", "all served", req_on_port, 16'hFFFF);

        // R6: all bypass in one bank
        clear_req();
        for (int r = 0; r < NR; r++) set_req(r, IW'((r << 4) | 7), 1'b1);
        apply();
        check("R6", "no ports", port_vld, '0);
        check("R6", "no reissue", slot_reissue, '0);
        // R6: bypass requests do not crowd four real reads
        clear_req();
        for (int r = 0; r < NR; r++) set_req(r, IW'((r << 4) | 7), r >= 4);
        apply();
        check("R6", "mixed no reissue", slot_reissue, '0);
        check("R6", "mixed on_port", req_on_port, 16'h000F);

        // R8 / R10: slot 2 op0 loses, op1 in another bank wins
        clear_req();
        for (int r = 0; r < 4; r++) set_req(r, IW'((r << 4) | 2), 1'b0);
        set_req(4, 9'h042, 1'b0);
        set_req(5, 9'h039, 1'b0);
        apply();
        check("R8", "slot2 flagged", slot_reissue, 8'h04);
        check("R8", "op1 keeps grant", req_on_port[5], 1'b1);
        check("R10", "loser psel zero", req_psel[9:8], 2'd0);

        // R7: invalid requests with random contents
        clear_req();
        idx = {$urandom, $urandom, $urandom, $urandom, $urandom};
        byp = 16'($urandom);
        apply();
        check("R7", "idle port_vld", port_vld, '0);
        check("R7", "idle reissue", slot_reissue, '0);

        // random groups from a small pool, back to back (R9)
        for (int n = 0; n < 400; n++) begin
            clear_req();
            for (int r = 0; r < NR; r++) begin
                vld[r] = ($urandom % 10) < 8;
                byp[r] = ($urandom % 10) < 2;
                idx[r*IW +: IW] = {4'($urandom % 3), 1'b0, 4'($urandom % 3)};
            end
            apply();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule